// File: doc/BRIEF.md
# Crystal-Clock PPM Trim Divider

This block turns an oscillator-rate clock enable into a one-pulse-per-second timebase. A nominal second is `NOM_COUNT` accepted enables (32768 by default). A three-bit trim code corrects crystal frequency error in fixed parts-per-million steps. The correction never changes the divide ratio for good. Instead, a fractional accumulator decides now and then that a second should take one or two counts more or fewer, so that the average count per second moves by the requested amount.

Bit 2 of the trim code is the sign of the correction. Bits 1 and 0 give the magnitude in multiples of `STEP_PPM` (20 ppm by default): bit 1 counts double and bit 0 counts single, for at most 60 ppm. At every second boundary the block adds magnitude × `NOM_COUNT` to an accumulator that wraps at `FRAC_MOD` (one million). The number of wraps, k, sets the length of the second that follows. That length is `NOM_COUNT`+k for a positive correction and `NOM_COUNT`−k for a negative one. At the default 60 ppm, k can reach 2.

Top module: `ppm_trim_divider`

## Requirements
- R1: A synchronous active-low reset clears the second counter and the accumulator, drops the strobe, and makes the first second after reset exactly `NOM_COUNT` accepted enables long. This is the same as trim code 000, no correction.
- R2: `sec_pulse` is high for exactly one clock cycle. That cycle directly follows the clock edge at which the enable that completes a second is accepted. The strobe is never high in two consecutive cycles.
- R3: A clock edge with `tick_en` low changes neither the count nor the strobe schedule. Only cycles with `tick_en` high advance the second.
- R4: Trim code decoding: bit 2 = 0 means more counts per second and 1 means fewer. Bit 1 weighs 2×`STEP_PPM` and bit 0 weighs 1×`STEP_PPM`. Magnitude zero gives seconds of exactly `NOM_COUNT` enables.
- R5: At each second boundary the accumulator gains magnitude_ppm × `NOM_COUNT`. Let k be the number of whole `FRAC_MOD` units this removes. The next second then lasts `NOM_COUNT`+k enables (sign 0) or `NOM_COUNT`−k enables (sign 1).
- R6: The trim code is sampled only at the enable that completes a second. A change in the middle of a second has no effect on that second's length.
- R7: A zero magnitude sampled at a boundary clears the accumulator. A later non-zero code therefore starts accumulating from zero.
- R8: The accumulator always stays below `FRAC_MOD`, and k never exceeds the largest value that the maximum code can produce.
- R9: Code 100 (negative sign, zero magnitude) behaves exactly like 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Oscillator-rate clock enable, one per oscillator cycle |
| trim_code | input | 3 | Bit 2 sign, bits 1:0 weighted ppm magnitude |
| sec_pulse | output | 1 | One-cycle seconds strobe |

## Verification
A wrong accumulator value stays hidden until it crosses the modulus. It then shows up as a second one count too long or too short, or as a correction missing from a second. Depending on the code, that can lie several seconds after the fault. For this reason the bench follows every code across many boundaries and compares the strobe with a behavioural model on every clock. A wrong count or sampling error shifts the very next strobe, so it shows within one second.

// File: rtl/ppm_trim_pkg.sv
// Package: shared types for the ppm trim divider.
// Assumes: a 3-bit trim code, sign in the top bit, weighted magnitude below.
package ppm_trim_pkg;

    localparam int CODE_W = 3;

    // Decoded trim code: direction plus magnitude in ppm steps (0..3).
    typedef struct packed {
        logic       slow;   // 1 = fewer counts per second
        logic [1:0] steps;  // magnitude in units of the ppm step
    } trim_t;

endpackage

// File: rtl/ppm_trim_decode.sv
// Module: ppm_trim_decode
// Splits the raw trim code into a direction and a magnitude in ppm steps.
// Assumes: bit 2 is the sign, bit 1 counts two steps, bit 0 counts one step,
// so the two low bits read as an unsigned step count.
module ppm_trim_decode
    import ppm_trim_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output trim_t             trim_o
);

    // Map the code bits onto the decoded fields.
    always_comb begin
        trim_o.slow  = code_i[2];
        trim_o.steps = {code_i[1], code_i[0]};
    end

endmodule

// File: rtl/ppm_frac_accum.sv
// Module: ppm_frac_accum
// Fractional accumulator that decides how many counts the next second gains
// or loses. At each boundary it adds steps*STEP_PPM*NOM_COUNT and removes
// whole FRAC_MOD units; that number of units is the correction for the next second.
// Assumes: boundary_i is high for one cycle per second; a zero step count
// at a boundary clears the accumulator.
module ppm_frac_accum #(
    parameter int NOM_COUNT = 32768,
    parameter int FRAC_MOD  = 1000000,
    parameter int STEP_PPM  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic [1:0]       steps_i,
    output logic [ppm_frac_accum_w(NOM_COUNT, FRAC_MOD, STEP_PPM, 0)-1:0] acc_o,
    output logic [ppm_frac_accum_w(NOM_COUNT, FRAC_MOD, STEP_PPM, 1)-1:0] wraps_o
);

    // Width helper: sel 0 gives accumulator width, sel 1 gives wrap-count width.
    function automatic int ppm_frac_accum_w(int nom, int md, int step, int sel);
        int max_add;
        int max_wrap;
        max_add  = 3 * step * nom;
        max_wrap = (md - 1 + max_add) / md;
        if (sel == 0) return $clog2(md + max_add);
        return $clog2(max_wrap + 1);
    endfunction

    localparam int MAX_ADD  = 3 * STEP_PPM * NOM_COUNT;
    localparam int MAX_WRAP = (FRAC_MOD - 1 + MAX_ADD) / FRAC_MOD;
    localparam int SUM_W    = $clog2(FRAC_MOD + MAX_ADD);
    localparam int WRAP_W   = $clog2(MAX_WRAP + 1);
    localparam logic [SUM_W-1:0] MOD_V  = SUM_W'(FRAC_MOD);
    localparam logic [SUM_W-1:0] UNIT_V = SUM_W'(STEP_PPM * NOM_COUNT);

    logic [SUM_W-1:0]  acc_q;
    logic [SUM_W-1:0]  acc_d;
    logic [WRAP_W-1:0] wraps_d;

    // Add this boundary's increment and peel off whole modulus units.
    always_comb begin
        logic [SUM_W-1:0] rem;
        rem     = acc_q + (SUM_W'(steps_i) * UNIT_V);
        wraps_d = '0;
        for (int i = 0; i < MAX_WRAP; i++) begin
            if (rem >= MOD_V) begin
                rem     = rem - MOD_V;
                wraps_d = wraps_d + WRAP_W'(1);
            end
        end
        acc_d = (steps_i == 2'd0) ? '0 : rem;
    end

    // Hold the fractional remainder between second boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (boundary_i) begin
            acc_q <= acc_d;
        end
    end

    assign acc_o   = acc_q;
    assign wraps_o = wraps_d;

endmodule

// File: rtl/ppm_second_counter.sv
// Module: ppm_second_counter
// Counts accepted clock enables up to the current second length, raises a
// registered one-cycle strobe when a second completes, and loads the length
// of the following second at that moment.
// Assumes: len_next_i is valid whenever an enable may complete a second, and
// every length is at least 2.
module ppm_second_counter #(
    parameter int NOM_COUNT = 32768,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [LEN_W-1:0] len_next_i,
    output logic             boundary_o,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] len_o,
    output logic             pulse_o
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             last;

    // Detect the enable that completes the current second.
    always_comb begin
        last       = (cnt_q == len_q - LEN_W'(1));
        boundary_o = tick_en && last;
    end

    // Advance the count on each enable and wrap at the second boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= last ? '0 : cnt_q + LEN_W'(1);
        end
    end

    // Load the next second's length only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LEN_W'(NOM_COUNT);
        end else if (boundary_o) begin
            len_q <= len_next_i;
        end
    end

    // Register the seconds strobe for one clock cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= boundary_o;
        end
    end

    assign cnt_o = cnt_q;
    assign len_o = len_q;

endmodule

// File: rtl/ppm_trim_divider.sv
// Module: ppm_trim_divider (top)
// Divides an oscillator-rate enable to a one-pulse-per-second strobe. A
// sign-plus-magnitude ppm code trims the average count per second through a
// fractional accumulator; single seconds gain or lose whole counts.
// Assumes: NOM_COUNT exceeds the largest per-second correction by at least 2.
module ppm_trim_divider
    import ppm_trim_pkg::*;
#(
    parameter int NOM_COUNT = 32768,
    parameter int FRAC_MOD  = 1000000,
    parameter int STEP_PPM  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] trim_code,
    output logic              sec_pulse
);

    localparam int MAX_ADD  = 3 * STEP_PPM * NOM_COUNT;
    localparam int MAX_WRAP = (FRAC_MOD - 1 + MAX_ADD) / FRAC_MOD;
    localparam int SUM_W    = $clog2(FRAC_MOD + MAX_ADD);
    localparam int WRAP_W   = $clog2(MAX_WRAP + 1);
    localparam int LEN_W    = $clog2(NOM_COUNT + MAX_WRAP + 1);
    localparam logic [LEN_W-1:0] NOM_V = LEN_W'(NOM_COUNT);

    trim_t             trim;
    logic              boundary;
    logic [SUM_W-1:0]  acc_val;
    logic [WRAP_W-1:0] wraps;
    logic [LEN_W-1:0]  len_next;
    logic [LEN_W-1:0]  cnt_val;
    logic [LEN_W-1:0]  len_val;

    ppm_trim_decode u_dec (
        .code_i (trim_code),
        .trim_o (trim)
    );

    ppm_frac_accum #(
        .NOM_COUNT (NOM_COUNT),
        .FRAC_MOD  (FRAC_MOD),
        .STEP_PPM  (STEP_PPM)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary),
        .steps_i    (trim.steps),
        .acc_o      (acc_val),
        .wraps_o    (wraps)
    );

    // Turn the wrap count and direction into the next second's length.
    always_comb begin
        if (trim.slow) begin
            len_next = NOM_V - LEN_W'(wraps);
        end else begin
            len_next = NOM_V + LEN_W'(wraps);
        end
    end

    ppm_second_counter #(
        .NOM_COUNT (NOM_COUNT),
        .LEN_W     (LEN_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .len_next_i (len_next),
        .boundary_o (boundary),
        .cnt_o      (cnt_val),
        .len_o      (len_val),
        .pulse_o    (sec_pulse)
    );

endmodule

// File: rtl/ppm_trim_checker.sv
// Module: ppm_trim_checker
// Temporal properties of the trim divider, bound to the top module.
// Assumes: the signals bound here are the top's internal nets of the same names.
module ppm_trim_checker #(
    parameter int NOM_COUNT = 32768,
    parameter int FRAC_MOD  = 1000000,
    parameter int STEP_PPM  = 20,
    parameter int SUM_W     = 21,
    parameter int WRAP_W    = 2,
    parameter int LEN_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              sec_pulse,
    input logic              boundary,
    input logic [1:0]        steps,
    input logic [SUM_W-1:0]  acc_val,
    input logic [WRAP_W-1:0] wraps,
    input logic [LEN_W-1:0]  cnt_val,
    input logic [LEN_W-1:0]  len_val
);

    localparam int MAX_WRAP = (FRAC_MOD - 1 + 3 * STEP_PPM * NOM_COUNT) / FRAC_MOD;

    // R1: state is clean one cycle after reset is applied.
    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_val == '0 && acc_val == '0 && !sec_pulse
                    && len_val == LEN_W'(NOM_COUNT)));

    // R2: the strobe never lasts two cycles.
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    // R2: the strobe follows a completing enable.
    assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(tick_en));

    // R3: no enable, no count movement.
    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_val));

    // R5: second length stays within the reachable range.
    assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(len_val) >= NOM_COUNT - MAX_WRAP) && (int'(len_val) <= NOM_COUNT + MAX_WRAP));

    // R6: the second length only changes at a boundary.
    assert_len_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(len_val));

    // R7: a zero magnitude at a boundary clears the accumulator.
    assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && steps == 2'd0) |=> (acc_val == '0 && len_val == LEN_W'(NOM_COUNT)));

    // R8: the accumulator stays below the modulus.
    assert_acc_below_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_val) < FRAC_MOD);

    // R8: the correction never exceeds the maximum wrap count.
    assert_wraps_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wraps) <= MAX_WRAP);

endmodule

bind ppm_trim_divider ppm_trim_checker #(
    .NOM_COUNT (NOM_COUNT),
    .FRAC_MOD  (FRAC_MOD),
    .STEP_PPM  (STEP_PPM),
    .SUM_W     (SUM_W),
    .WRAP_W    (WRAP_W),
    .LEN_W     (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .sec_pulse (sec_pulse),
    .boundary  (boundary),
    .steps     (trim.steps),
    .acc_val   (acc_val),
    .wraps     (wraps),
    .cnt_val   (cnt_val),
    .len_val   (len_val)
);

// File: tb/ppm_trim_divider_tb.sv
// Bench: behavioural reference model compared with the strobe on every clock.
module ppm_trim_divider_tb;

    localparam int NOM  = 256;
    localparam int MODV = 10000;
    localparam int STEP = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] trim_code = 3'b000;
    logic       sec_pulse;

    int    vectors = 0;
    int    errors  = 0;
    int    cycles  = 0;
    string tag     = "R1";

    // Reference model state (plain integers).
    int m_cnt = 0;
    int m_len = NOM;
    int m_acc = 0;
    bit m_exp = 1'b0;

    always #4 clk = ~clk;

    ppm_trim_divider #(
        .NOM_COUNT (NOM),
        .FRAC_MOD  (MODV),
        .STEP_PPM  (STEP)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .trim_code (trim_code),
        .sec_pulse (sec_pulse)
    );

    // Model: count enables, pick the next length from the code at each boundary.
    always @(posedge clk) begin
        int mag;
        int k;
        if (!rst_n) begin
            m_cnt = 0; m_len = NOM; m_acc = 0; m_exp = 1'b0;
        end else begin
            m_exp = 1'b0;
            if (tick_en) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == m_len) begin
                    m_exp = 1'b1;
                    m_cnt = 0;
                    mag = 40 * trim_code[1] + 20 * trim_code[0];
                    if (mag == 0) begin
                        m_acc = 0; k = 0;
                    end else begin
                        m_acc = m_acc + mag * NOM;
                        k     = m_acc / MODV;
                        m_acc = m_acc % MODV;
                    end
                    m_len = trim_code[2] ? NOM - k : NOM + k;
                end
            end
        end
    end

    // Compare the strobe with the model away from the active edge.
    always @(negedge clk) begin
        vectors++;
        if (sec_pulse !== m_exp) begin
            errors++;
            $display("FAIL %s: sec_pulse=%0b expected=%0b at cycle %0d", tag, sec_pulse, m_exp, cycles);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Run until n strobes are seen, enables with the given density in percent.
    task automatic run_seconds(input int n, input int density);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (sec_pulse) seen++;
            tick_en = (($urandom % 100) < density);
        end
    endtask

    // Change the code at a random point inside a second (R6).
    task automatic mid_change(input logic [2:0] c);
        int wait_n = 20 + ($urandom % 150);
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        trim_code = c;
    endtask

    initial begin
        // R1: reset state and first nominal second.
        tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_seconds(2, 100);
        // R4: zero magnitude, dense and sparse enables.
        tag = "R4";
        run_seconds(3, 100);
        // R3: sparse enables freeze the count in idle cycles.
        tag = "R3";
        run_seconds(3, 30);
        // R5: full positive then full negative correction.
        tag = "R5";
        trim_code = 3'b011;
        run_seconds(8, 80);
        trim_code = 3'b111;
        run_seconds(8, 90);
        trim_code = 3'b001;
        run_seconds(12, 75);
        trim_code = 3'b110;
        run_seconds(8, 100);
        // R9: negative zero equals zero.
        tag = "R9";
        trim_code = 3'b100;
        run_seconds(4, 85);
        // R7: zero clears the accumulator, then restart.
        tag = "R7";
        trim_code = 3'b011;
        run_seconds(1, 100);
        trim_code = 3'b000;
        run_seconds(2, 100);
        trim_code = 3'b011;
        run_seconds(4, 100);
        // R6: changes in the middle of a second.
        tag = "R6";
        for (int j = 0; j < 8; j++) begin
            mid_change(3'(($urandom % 8)));
            run_seconds(1, 100);
        end
        // R8: long run at maximum magnitude keeps correct lengths.
        tag = "R8";
        trim_code = 3'b011;
        run_seconds(20, 100);
        // R1: reset in mid-second restores the nominal first second.
        tag = "R1";
        mid_change(3'b111);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        trim_code = 3'b000;
        run_seconds(2, 100);
        // R2: final stretch with enables every cycle.
        tag = "R2";
        trim_code = 3'b101;
        run_seconds(6, 100);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule